// File: doc/BRIEF.md
# PCM Receive Word Deserializer with Attenuation Code

This block turns the serial receive side of a voice-band PCM port into parallel samples. It runs on a master clock that oversamples both bit clocks, the receive frame sync, the transmit frame sync and the serial data. In normal operation it shifts in a 13-bit two's-complement word, MSB first, on falling edges of the receive bit clock. It accepts both a one-edge (short) frame sync and a multi-edge (long) frame sync.

When the receive bit clock stops toggling, its held level becomes a mode select. A low level selects a 16-bit word whose four leading bits all carry the sign. A high level selects a 16-bit word whose three trailing bits hold an attenuation code, where each code step is 3 dB more attenuation, from 0 dB at code 0 to 21 dB at code 7. In both 16-bit modes the word is clocked by the transmit bit clock. If a transmit frame passes with no receive frame sync, the sample output is cleared to zero so that stale audio is not replayed.

Top module: `pcm_rx_deser`

## Requirements
- R1: In normal mode (`mode`=00) the block captures 13 bits, MSB first, on falling edges of `rx_bclk`. When the last bit is captured, `sample` shows them as a two's-complement word.
- R2: A frame sync that is high on exactly one falling edge is a short sync. The bit on that edge is discarded, and the first data bit is taken on the next falling edge.
- R3: A frame sync that is high on two consecutive falling edges is a long sync. The first data bit is the one captured on the first of those edges.
- R4: If `rx_bclk` shows no edge for STALL_CYC (default 16) master-clock cycles, `mode` follows its held level: low gives 01 (sign-extended), high gives 10 (attenuation). Any edge on `rx_bclk` returns `mode` to 00 on the next cycle. Code 11 never appears.
- R5: In modes 01 and 10 the word is 16 bits long and is captured on falling edges of `tx_bclk`, still framed by `rx_fs`.
- R6: In mode 01, `sample` takes the last 13 bits of the word, so the fourth bit is the sign. If the first four bits disagree, `fmt_err` pulses together with `sample_vld`.
- R7: In mode 10, `sample` takes the first 13 bits of the word and `atten` takes bits 14 to 16, with bit 14 as the MSB. The attenuation is 3 dB times the code.
- R8: `atten` is 000 (0 dB) whenever the block is not in mode 10.
- R9: `sample_vld` is high for exactly one master-clock cycle per completed word. `sample` holds its value between words.
- R10: If a rising edge of `tx_fs` arrives and no rising edge of `rx_fs` has occurred since the previous `tx_fs` rising edge, `sample` becomes zero. This does not raise `sample_vld`.
- R11: In normal mode the position of `tx_fs` within a receive frame has no effect on the captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, oversamples all PCM pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bclk | input | 1 | Receive bit clock, or static mode level when held |
| tx_bclk | input | 1 | Transmit bit clock, used by the 16-bit modes |
| rx_fs | input | 1 | Receive frame sync |
| tx_fs | input | 1 | Transmit frame sync, used only to detect a missing receive sync |
| rx_data | input | 1 | Serial receive data |
| sample | output | 13 | Received two's-complement sample |
| atten | output | 3 | Attenuation code, 3 dB per step |
| sample_vld | output | 1 | One-cycle strobe for a new word |
| fmt_err | output | 1 | Leading bits disagreed in sign-extended mode |
| mode | output | 2 | 00 normal, 01 sign-extended, 10 attenuation |

## Verification
The assertions check, on every cycle, that the strobe lasts a single cycle and that the sample stays stable between words. They also check that the attenuation code stays zero outside mode 10, that a full stall window forces a special mode, that an edge on `rx_bclk` returns the block to normal mode, and that a missing receive sync clears the sample. Only the bench scenarios can show that the right bits land in the right place. That covers short and long sync alignment, the field split in each 16-bit mode, the sign-agreement error, the two-frame timing of the zero rule, and independence from the transmit sync position.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    typedef enum logic [1:0] {
        RXM_NORM = 2'b00,
        RXM_SEXT = 2'b01,
        RXM_GAIN = 2'b10
    } rx_mode_e;
endpackage

// File: rtl/pcm_rx_pinsync.sv
module pcm_rx_pinsync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cur  = pin_i;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign fall_o[g] = st_q.prev[g] & ~st_q.cur[g];
        assign rise_o[g] = ~st_q.prev[g] & st_q.cur[g];
    end

    assign cur_o = st_q.cur;
endmodule

// File: rtl/pcm_rx_clkmon.sv
module pcm_rx_clkmon
    import pcm_rx_pkg::*;
#(
    parameter int STALL_CYC = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lvl_i,
    input  logic     edge_i,
    output rx_mode_e mode_o,
    output logic     chg_o
);
    localparam int SC_W = $clog2(STALL_CYC + 1);
    localparam logic [SC_W-1:0] LIM = SC_W'(STALL_CYC - 1);

    typedef struct packed {
        logic [SC_W-1:0] cnt;
        rx_mode_e        mode;
        logic            chg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.cnt  = '0;
            st_d.mode = RXM_NORM;
        end else if (st_q.cnt == LIM) begin
            st_d.mode = lvl_i ? RXM_GAIN : RXM_SEXT;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.chg = (st_d.mode != st_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, mode: RXM_NORM, chg: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
    assign chg_o  = st_q.chg;

    AST_EDGE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (mode_o == RXM_NORM)); // R4
    AST_STALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LIM && !edge_i) |=> (mode_o != RXM_NORM)); // R4
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11); // R4
endmodule

// File: rtl/pcm_rx_frmwatch.sv
module pcm_rx_frmwatch (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rise_i,
    input  logic rx_rise_i,
    output logic idle_o
);
    typedef struct packed {
        logic seen;
        logic idle;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.idle = tx_rise_i && !st_q.seen && !rx_rise_i;
        if (tx_rise_i) st_d.seen = rx_rise_i;
        else           st_d.seen = st_q.seen | rx_rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_o = st_q.idle;
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int EXT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fe_i,
    input  logic                fs_i,
    input  logic                dat_i,
    input  rx_mode_e            mode_i,
    input  logic                abort_i,
    input  logic                idle_zero_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [EXT_W-1:0]    atten_o,
    output logic                vld_o,
    output logic                err_o
);
    localparam int WORD_W = SAMPLE_W + EXT_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] NORM_LEN = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] WIDE_LEN = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0]   shreg;
        logic [CNT_W-1:0]    cnt;
        logic                busy;
        logic                first;
        logic                fs_last;
        logic [SAMPLE_W-1:0] sample;
        logic [EXT_W-1:0]    atten;
        logic                vld;
        logic                err;
    } state_t;

    state_t            st_d, st_q;
    logic [CNT_W-1:0]  wlen;
    logic [EXT_W:0]    lead;

    assign wlen = (mode_i == RXM_NORM) ? NORM_LEN : WIDE_LEN;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        lead     = '0;
        if (mode_i != RXM_GAIN) st_d.atten = '0;
        if (abort_i) begin
            st_d.busy  = 1'b0;
            st_d.first = 1'b0;
        end else if (fe_i) begin
            st_d.fs_last = fs_i;
            if (fs_i && !st_q.fs_last) begin
                st_d.busy  = 1'b1;
                st_d.first = 1'b1;
                st_d.cnt   = CNT_W'(1);
                st_d.shreg = {{(WORD_W-1){1'b0}}, dat_i};
            end else if (st_q.busy) begin
                st_d.first = 1'b0;
                if (st_q.first && !fs_i) begin
                    st_d.cnt   = CNT_W'(1);
                    st_d.shreg = {{(WORD_W-1){1'b0}}, dat_i};
                end else begin
                    st_d.cnt   = st_q.cnt + 1'b1;
                    st_d.shreg = {st_q.shreg[WORD_W-2:0], dat_i};
                end
            end
            if (st_d.busy && st_d.cnt == wlen) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
                lead      = st_d.shreg[WORD_W-1:SAMPLE_W-1];
                unique case (mode_i)
                    RXM_GAIN: begin
                        st_d.sample = st_d.shreg[WORD_W-1:EXT_W];
                        st_d.atten  = st_d.shreg[EXT_W-1:0];
                    end
                    RXM_SEXT: begin
                        st_d.sample = st_d.shreg[SAMPLE_W-1:0];
                        st_d.err    = !((&lead) || !(|lead));
                    end
                    default: st_d.sample = st_d.shreg[SAMPLE_W-1:0];
                endcase
            end
        end
        if (idle_zero_i && !st_d.vld) st_d.sample = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign atten_o  = st_q.atten;
    assign vld_o    = st_q.vld;
    assign err_o    = st_q.err;

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R9
    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_o && !$past(idle_zero_i)) |-> $stable(sample_o)); // R9
    AST_ERR_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> vld_o); // R6
    AST_ATTEN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != RXM_GAIN && $past(mode_i) != RXM_GAIN) |-> atten_o == '0); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= WIDE_LEN); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        idle_zero_i |=> (sample_o == '0 || vld_o)); // R10
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_rx_pkg::*;
#(
    parameter int SAMPLE_W  = 13,
    parameter int EXT_W     = 3,
    parameter int STALL_CYC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_bclk,
    input  logic                tx_bclk,
    input  logic                rx_fs,
    input  logic                tx_fs,
    input  logic                rx_data,
    output logic [SAMPLE_W-1:0] sample,
    output logic [EXT_W-1:0]    atten,
    output logic                sample_vld,
    output logic                fmt_err,
    output logic [1:0]          mode
);
    localparam int NPIN   = 5;
    localparam int P_RCLK = 0;
    localparam int P_TCLK = 1;
    localparam int P_RFS  = 2;
    localparam int P_TFS  = 3;
    localparam int P_DAT  = 4;

    logic [NPIN-1:0] cur, fall, rise;
    rx_mode_e        mode_q;
    logic            mode_chg;
    logic            idle_zero;
    logic            fe_act;

    pcm_rx_pinsync #(.N(NPIN)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({rx_data, tx_fs, rx_fs, tx_bclk, rx_bclk}),
        .cur_o  (cur),
        .fall_o (fall),
        .rise_o (rise)
    );

    pcm_rx_clkmon #(.STALL_CYC(STALL_CYC)) i_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (cur[P_RCLK]),
        .edge_i (fall[P_RCLK] | rise[P_RCLK]),
        .mode_o (mode_q),
        .chg_o  (mode_chg)
    );

    pcm_rx_frmwatch i_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_rise_i (rise[P_TFS]),
        .rx_rise_i (rise[P_RFS]),
        .idle_o    (idle_zero)
    );

    assign fe_act = (mode_q == RXM_NORM) ? fall[P_RCLK] : fall[P_TCLK];

    pcm_rx_shifter #(.SAMPLE_W(SAMPLE_W), .EXT_W(EXT_W)) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .fe_i        (fe_act),
        .fs_i        (cur[P_RFS]),
        .dat_i       (cur[P_DAT]),
        .mode_i      (mode_q),
        .abort_i     (mode_chg),
        .idle_zero_i (idle_zero),
        .sample_o    (sample),
        .atten_o     (atten),
        .vld_o       (sample_vld),
        .err_o       (fmt_err)
    );

    assign mode = mode_q;
endmodule

// File: tb/test_pcm_rx_deser.sv
module test_pcm_rx_deser;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bclk = 1'b0, tx_bclk = 1'b0, rx_fs = 1'b0, tx_fs = 1'b0, rx_data = 1'b0;
    logic [12:0] sample;
    logic [2:0]  atten;
    logic        sample_vld, fmt_err;
    logic [1:0]  mode;

    int   total = 0, bad = 0, nvld = 0;
    bit   fin = 0;
    bit   rx_run = 1;
    logic rx_lvl = 1'b0;
    logic [12:0] got_s;
    logic [2:0]  got_a;
    logic        got_e;

    always #2 clk = ~clk;

    pcm_rx_deser i_pcm_rx_deser (
        .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .tx_bclk(tx_bclk),
        .rx_fs(rx_fs), .tx_fs(tx_fs), .rx_data(rx_data),
        .sample(sample), .atten(atten), .sample_vld(sample_vld),
        .fmt_err(fmt_err), .mode(mode)
    );

    always @(negedge clk) if (sample_vld) begin
        nvld++;
        got_s = sample;
        got_a = atten;
        got_e = fmt_err;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic fs, input logic tfs, input logic d);
        @(negedge clk);
        tx_bclk = 1'b1;
        rx_bclk = rx_run ? 1'b1 : rx_lvl;
        rx_fs = fs; tx_fs = tfs; rx_data = d;
        repeat (HALF) @(negedge clk);
        tx_bclk = 1'b0;
        rx_bclk = rx_run ? 1'b0 : rx_lvl;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int n, input bit lng, input int txoff);
        if (lng) begin
            for (int i = 0; i < n; i++) tick(i < 2, txoff == i, w[n-1-i]);
        end else begin
            tick(1'b1, txoff == 0, 1'($urandom));
            for (int i = 0; i < n; i++) tick(1'b0, txoff == i + 1, w[n-1-i]);
        end
        repeat (3) tick(1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [12:0] exp_s(input logic [1:0] m, input logic [15:0] w);
        return (m == 2'b10) ? w[15:3] : w[12:0];
    endfunction

    function automatic logic exp_e(input logic [1:0] m, input logic [15:0] w);
        return (m == 2'b01) && !((&w[15:12]) || !(|w[15:12]));
    endfunction

    task automatic word(input logic [1:0] m, input logic [15:0] w, input bit lng,
                        input int txoff, input string req);
        int n0 = nvld;
        send(w, (m == 2'b00) ? 13 : 16, lng, txoff);
        chk(nvld == n0 + 1, {req, " R9 strobe count"}, nvld - n0, 1);
        chk(got_s == exp_s(m, w), {req, " sample"}, got_s, exp_s(m, w));
        chk(got_a == ((m == 2'b10) ? w[2:0] : 3'd0), {req, " R8/R7 atten"}, got_a,
            (m == 2'b10) ? w[2:0] : 3'd0);
        chk(got_e == exp_e(m, w), {req, " R6 fmt_err"}, got_e, exp_e(m, w));
    endtask

    task automatic set_mode(input bit run, input logic lvl, input logic [1:0] m);
        rx_run = run; rx_lvl = lvl;
        repeat (6) tick(1'b0, 1'b0, 1'b0);
        chk(mode == m, "R4 mode select", mode, m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [12:0] s;
        logic [12:0] keep;
        int n0;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample == 13'd0 && !sample_vld && !fmt_err, "R9 reset outputs", sample, 0);
        chk(mode == 2'b00, "R4 reset mode", mode, 0);
        chk(atten == 3'd0, "R8 reset atten", atten, 0);

        // R1 R2 R3: normal mode, corners then random
        word(2'b00, 16'h1000, 1'b0, 0, "R2 short most-negative");
        word(2'b00, 16'h0FFF, 1'b1, 0, "R3 long most-positive");
        word(2'b00, 16'h0000, 1'b0, 0, "R1 zero");
        word(2'b00, 16'h1FFF, 1'b1, 0, "R1 minus one");
        for (int k = 0; k < 12; k++)
            word(2'b00, 16'($urandom) & 16'h1FFF, k[0], 0, "R1 random");
        // R11: transmit sync at arbitrary offsets
        for (int k = 0; k < 6; k++)
            word(2'b00, 16'($urandom) & 16'h1FFF, k[0], 2 + ($urandom % 10), "R11 async tx_fs");

        // R10: one missed receive frame keeps sample, two clear it
        word(2'b00, 16'h0ABC, 1'b0, 0, "R10 setup");
        keep = sample;
        n0 = nvld;
        tick(1'b0, 1'b1, 1'b0);
        repeat (15) tick(1'b0, 1'b0, 1'b0);
        chk(sample == keep, "R10 stale kept after one tx frame", sample, keep);
        tick(1'b0, 1'b1, 1'b0);
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        chk(sample == 13'd0, "R10 zero after missing rx sync", sample, 0);
        chk(nvld == n0, "R10 no strobe", nvld - n0, 0);

        // R4 R5 R6: sign-extended mode on the transmit clock
        set_mode(1'b0, 1'b0, 2'b01);
        word(2'b01, 16'hF000, 1'b0, 0, "R6 negative extended");
        word(2'b01, 16'h0FFF, 1'b1, 0, "R5 long positive extended");
        word(2'b01, 16'h7123, 1'b0, 0, "R6 bad leading bits");
        word(2'b01, 16'h9000, 1'b1, 0, "R6 sign from fourth bit");
        for (int k = 0; k < 6; k++) begin
            s = 13'($urandom);
            word(2'b01, {{3{s[12]}}, s}, k[0], 0, "R6 random");
        end
        chk(atten == 3'd0, "R8 atten idle in mode 01", atten, 0);

        // R4 R7: attenuation mode
        set_mode(1'b0, 1'b1, 2'b10);
        for (int c = 0; c < 8; c++) begin
            w = {13'($urandom), 3'(c)};
            word(2'b10, w, c[0], 0, "R7 code sweep");
        end
        chk(atten == 3'd7, "R7 atten held", atten, 7);

        // back to normal: attenuation returns to zero
        set_mode(1'b1, 1'b0, 2'b00);
        chk(atten == 3'd0, "R8 atten cleared in mode 00", atten, 0);
        word(2'b00, 16'h1555, 1'b0, 0, "R1 after return");

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule